// File: doc/BRIEF.md
# Multi-Word Mailbox Message Transmitter

This block sends a message of a given byte length over a group of consecutive mailbox channel windows. The message sits outside the block as a sequence of 32-bit words, and the block fetches them one at a time through a combinational word-read port. The message goes out in rounds. A round carries at most one word per window. Inside a round the block writes from the lowest window up to the highest. The highest window is the only one the receiver leaves unmasked, so its write is the last one and raises the receiver's interrupt.

Before each round, the block checks the word that will land in the highest window. A zero in that word could not signal the receiver, so the transfer stops with an error. Otherwise the block waits until the status of the highest window reads zero, meaning the receiver has taken the previous round. In the final round, slots that the remaining byte count does not reach are skipped. A last word holding fewer than four bytes has its unused upper bytes cleared.

Writes leave through a valid/ready register-write master, one write at a time, each carrying a window index and a data word. A message source starts a transfer with a start pulse. While a transfer is in progress, the block shows busy and ignores further starts.

Top module: `mbx_msg_tx`

## Requirements
- R1: While reset is asserted, and after it is released, `busy_o`, `err_o` and `wr_valid_o` are 0.
- R2: With W windows per channel and base window B, the word at offset i of a round (data index round_start+i) is written to window B+W-1-i. Writes within a round go in descending i, so window B+W-1 is written last in every round.
- R3: `poll_win_o` equals B+W-1. No write of a round is issued until `poll_stat_i` has been sampled as zero after that round's leading-word check. While `poll_stat_i` stays nonzero the block stays busy and writes nothing.
- R4: The round start index is 0 for the first round and grows by W for each later round. If the word at the round start index is zero, `err_o` becomes 1 and `busy_o` falls in the same cycle, with no write of that round issued.
- R5: In the final round, a slot i is not written when the remaining byte count for the round is at most 4*i.
- R6: When the last word carries k bytes (k = 1, 2 or 3), bits 8k-1:0 of the written data equal the source word and all higher bits are zero.
- R7: Each write lowers the remaining count by 4, or by k for a partial word. `busy_o` falls the cycle after the handshake that brings the count to zero.
- R8: A start pulse while `busy_o` is 1 is ignored: the transfer in progress is unchanged and no write of the refused message is issued.
- R9: While `wr_valid_o` is 1 and `wr_ready_i` is 0, `wr_valid_o`, `wr_win_o` and `wr_data_o` hold their values into the next cycle.
- R10: `err_o` stays at 1 until the next accepted start, which clears it. A start with length 0 is accepted, clears `err_o`, issues no write and leaves `busy_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new message |
| len_i | input | LEN_W | Message length in bytes, sampled at start |
| base_i | input | WIN_IDX_W | Lowest window of the channel, sampled at start |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Last transfer stopped on a zero leading word |
| rd_idx_o | output | LEN_W | Index of the message word requested |
| rd_word_i | input | WORD_W | Message word at `rd_idx_o`, same cycle |
| poll_win_o | output | WIN_IDX_W | Window whose status gates each round (highest window) |
| poll_stat_i | input | WORD_W | Status of `poll_win_o` window, zero when empty |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write accepted |
| wr_win_o | output | WIN_IDX_W | Target window of the write |
| wr_data_o | output | WORD_W | Word to set in the window |

## Verification
The table of transfers covers these cases:
- A length of exactly one round, which checks the window order on its own.
- Lengths spanning two and three rounds, which check that the round index advances.
- Lengths ending in one- and three-byte partial words, which separate the masking from the slot skipping.
- A single-word message at the top of the window range.

Half of these transfers run with the write master stalling on alternate cycles, so a hold-stable fault or a skipped handshake shows up as a wrong write list. Directed cases cover:
- A zero word at the start of the first round and of a later round, so the error is separated from an ordinary end.
- A nonzero status held across a start.
- A start arriving during a busy transfer.
- A zero-length start used to clear a standing error.

// File: rtl/mbx_tx_pkg.sv
package mbx_tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_WAIT  = 2'd2,
      ST_WRITE = 2'd3
   } tx_state_e;

endpackage

// File: rtl/mbx_round_calc.sv
// Sizes the next round: bytes it carries and the highest slot it touches.
module mbx_round_calc #(
   parameter int LEN_W      = 12,
   parameter int WIN_PER_CH = 4,
   parameter int BYTES      = 4,
   parameter int SLOT_W     = 2
) (
   input  logic [LEN_W-1:0]  rem_i,
   output logic [LEN_W-1:0]  rnd_bytes_o,
   output logic [SLOT_W-1:0] top_slot_o
);

   localparam int CAP    = WIN_PER_CH * BYTES;
   localparam int BSEL_W = $clog2(BYTES);

   logic [LEN_W-1:0] words;

   always_comb begin
      rnd_bytes_o = (rem_i < LEN_W'(CAP)) ? rem_i : LEN_W'(CAP);
      words       = (rnd_bytes_o + LEN_W'(BYTES - 1)) >> BSEL_W;
      top_slot_o  = SLOT_W'(words - LEN_W'(1));
   end

endmodule

// File: rtl/mbx_byte_keep.sv
// Keeps the low keep_cnt_i bytes of a word (0 means the whole word).
module mbx_byte_keep #(
   parameter int WORD_W = 32,
   parameter int BYTES  = WORD_W / 8,
   parameter int BSEL_W = $clog2(BYTES)
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [BSEL_W-1:0] keep_cnt_i,
   output logic [WORD_W-1:0] word_o,
   output logic [BSEL_W:0]   sent_o
);

   logic whole;
   assign whole  = (keep_cnt_i == '0);
   assign sent_o = whole ? (BSEL_W + 1)'(BYTES) : {1'b0, keep_cnt_i};

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic lane_on;
      assign lane_on           = whole || (BSEL_W'(b) < keep_cnt_i);
      assign word_o[b*8 +: 8]  = lane_on ? word_i[b*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/mbx_tx_ctrl.sv
// Sequencer: leading-word check, status wait, descending slot writes.
module mbx_tx_ctrl
   import mbx_tx_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int WIN_PER_CH = 4,
   parameter int WIN_IDX_W  = 7,
   parameter int WORD_W     = 32,
   parameter int SLOT_W     = 2,
   parameter int BSEL_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [LEN_W-1:0]     len_i,
   input  logic [WIN_IDX_W-1:0] base_i,
   input  logic [WORD_W-1:0]    rd_word_i,
   input  logic [WORD_W-1:0]    poll_stat_i,
   input  logic                 wr_ready_i,
   input  logic [LEN_W-1:0]     rnd_bytes_i,
   input  logic [SLOT_W-1:0]    top_slot_i,
   input  logic [BSEL_W:0]      sent_i,
   output logic                 busy_o,
   output logic                 err_o,
   output logic [LEN_W-1:0]     rd_idx_o,
   output logic [WIN_IDX_W-1:0] poll_win_o,
   output logic                 wr_valid_o,
   output logic [WIN_IDX_W-1:0] wr_win_o,
   output logic [BSEL_W-1:0]    keep_cnt_o,
   output logic [LEN_W-1:0]     rem_o
);

   tx_state_e            state_q;
   logic [WIN_IDX_W-1:0] base_q;
   logic [LEN_W-1:0]     rem_q;
   logic [LEN_W-1:0]     idx_q;
   logic [LEN_W-1:0]     rnd_left_q;
   logic [SLOT_W-1:0]    slot_q;
   logic                 err_q;
   logic [LEN_W-1:0]     sent_ext;

   assign sent_ext   = LEN_W'(sent_i);
   assign busy_o     = (state_q != ST_IDLE);
   assign err_o      = err_q;
   assign wr_valid_o = (state_q == ST_WRITE);
   assign poll_win_o = base_q + WIN_IDX_W'(WIN_PER_CH - 1);
   assign wr_win_o   = poll_win_o - WIN_IDX_W'(slot_q);
   assign keep_cnt_o = rnd_left_q[BSEL_W-1:0];
   assign rem_o      = rem_q;
   assign rd_idx_o   = (state_q == ST_WRITE) ? idx_q + LEN_W'(slot_q) : idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         base_q     <= '0;
         rem_q      <= '0;
         idx_q      <= '0;
         rnd_left_q <= '0;
         slot_q     <= '0;
         err_q      <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  err_q <= 1'b0;
                  if (len_i != '0) begin
                     base_q  <= base_i;
                     rem_q   <= len_i;
                     idx_q   <= '0;
                     state_q <= ST_CHECK;
                  end
               end
            end
            ST_CHECK: begin
               if (rd_word_i == '0) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (poll_stat_i == '0) begin
                  rnd_left_q <= rnd_bytes_i;
                  slot_q     <= top_slot_i;
                  state_q    <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (wr_ready_i) begin
                  rem_q      <= rem_q - sent_ext;
                  rnd_left_q <= rnd_left_q - sent_ext;
                  if (slot_q == '0) begin
                     idx_q   <= idx_q + LEN_W'(WIN_PER_CH);
                     state_q <= (rem_q == sent_ext) ? ST_IDLE : ST_CHECK;
                  end else begin
                     slot_q <= slot_q - SLOT_W'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mbx_msg_tx.sv
// Top: multi-word mailbox message transmitter.
module mbx_msg_tx #(
   parameter int WIN_CNT    = 124,
   parameter int WIN_PER_CH = 4,
   parameter int LEN_W      = 12,
   parameter int WORD_W     = 32,
   localparam int WIN_IDX_W = $clog2(WIN_CNT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [LEN_W-1:0]     len_i,
   input  logic [WIN_IDX_W-1:0] base_i,
   output logic                 busy_o,
   output logic                 err_o,
   output logic [LEN_W-1:0]     rd_idx_o,
   input  logic [WORD_W-1:0]    rd_word_i,
   output logic [WIN_IDX_W-1:0] poll_win_o,
   input  logic [WORD_W-1:0]    poll_stat_i,
   output logic                 wr_valid_o,
   input  logic                 wr_ready_i,
   output logic [WIN_IDX_W-1:0] wr_win_o,
   output logic [WORD_W-1:0]    wr_data_o
);

   localparam int BYTES  = WORD_W / 8;
   localparam int BSEL_W = $clog2(BYTES);
   localparam int SLOT_W = (WIN_PER_CH > 1) ? $clog2(WIN_PER_CH) : 1;

   if (WORD_W % 8 != 0 || BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_word
      $error("mbx_msg_tx: WORD_W must be a power-of-two count of bytes, at least 2");
   end
   if (WIN_PER_CH < 1 || WIN_PER_CH > WIN_CNT) begin : g_bad_win
      $error("mbx_msg_tx: WIN_PER_CH must lie in 1..WIN_CNT");
   end
   if ((1 << LEN_W) <= WIN_PER_CH * BYTES) begin : g_bad_len
      $error("mbx_msg_tx: LEN_W too narrow for one round");
   end

   logic [LEN_W-1:0]  rem;
   logic [LEN_W-1:0]  rnd_bytes;
   logic [SLOT_W-1:0] top_slot;
   logic [BSEL_W-1:0] keep_cnt;
   logic [BSEL_W:0]   sent;

   mbx_round_calc #(
      .LEN_W      (LEN_W),
      .WIN_PER_CH (WIN_PER_CH),
      .BYTES      (BYTES),
      .SLOT_W     (SLOT_W)
   ) u_calc (
      .rem_i       (rem),
      .rnd_bytes_o (rnd_bytes),
      .top_slot_o  (top_slot)
   );

   mbx_byte_keep #(
      .WORD_W (WORD_W),
      .BYTES  (BYTES),
      .BSEL_W (BSEL_W)
   ) u_keep (
      .word_i     (rd_word_i),
      .keep_cnt_i (keep_cnt),
      .word_o     (wr_data_o),
      .sent_o     (sent)
   );

   mbx_tx_ctrl #(
      .LEN_W      (LEN_W),
      .WIN_PER_CH (WIN_PER_CH),
      .WIN_IDX_W  (WIN_IDX_W),
      .WORD_W     (WORD_W),
      .SLOT_W     (SLOT_W),
      .BSEL_W     (BSEL_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .len_i       (len_i),
      .base_i      (base_i),
      .rd_word_i   (rd_word_i),
      .poll_stat_i (poll_stat_i),
      .wr_ready_i  (wr_ready_i),
      .rnd_bytes_i (rnd_bytes),
      .top_slot_i  (top_slot),
      .sent_i      (sent),
      .busy_o      (busy_o),
      .err_o       (err_o),
      .rd_idx_o    (rd_idx_o),
      .poll_win_o  (poll_win_o),
      .wr_valid_o  (wr_valid_o),
      .wr_win_o    (wr_win_o),
      .keep_cnt_o  (keep_cnt),
      .rem_o       (rem)
   );

endmodule

// File: rtl/mbx_msg_tx_chk.sv
module mbx_msg_tx_chk #(
   parameter int WIN_PER_CH = 4,
   parameter int WIN_IDX_W  = 7,
   parameter int WORD_W     = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic                 busy_o,
   input logic                 err_o,
   input logic [WIN_IDX_W-1:0] poll_win_o,
   input logic [WORD_W-1:0]    poll_stat_i,
   input logic                 wr_valid_o,
   input logic                 wr_ready_i,
   input logic [WIN_IDX_W-1:0] wr_win_o,
   input logic [WORD_W-1:0]    wr_data_o
);

   logic [WIN_IDX_W:0] win_dist;
   assign win_dist = {1'b0, poll_win_o - wr_win_o};

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_win_o) && $stable(wr_data_o)));

   // R2
   top_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && wr_ready_i && wr_win_o == poll_win_o) |=> !wr_valid_o);

   // R2
   win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> (win_dist < (WIN_IDX_W + 1)'(WIN_PER_CH)));

   // R3
   poll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid_o) |-> ($past(poll_stat_i) == '0));

   // R4
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $fell(busy_o));

   // R10
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_o) |-> $past(start_i));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !wr_valid_o);

endmodule

bind mbx_msg_tx mbx_msg_tx_chk #(
   .WIN_PER_CH (WIN_PER_CH),
   .WIN_IDX_W  (WIN_IDX_W),
   .WORD_W     (WORD_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .err_o       (err_o),
   .poll_win_o  (poll_win_o),
   .poll_stat_i (poll_stat_i),
   .wr_valid_o  (wr_valid_o),
   .wr_ready_i  (wr_ready_i),
   .wr_win_o    (wr_win_o),
   .wr_data_o   (wr_data_o)
);

// File: tb/test_mbx_msg_tx.sv
module test_mbx_msg_tx;

   localparam int CLK_PERIOD = 10;
   localparam int WPC        = 4;
   localparam int NVEC       = 6;

   // stimulus / expected vectors: length, base window, stall, expected writes
   localparam int VLEN  [NVEC] = '{16, 24, 7, 9, 34, 4};
   localparam int VBASE [NVEC] = '{0, 5, 10, 2, 100, 120};
   localparam int VSTALL[NVEC] = '{0, 1, 0, 1, 1, 0};
   localparam int VNW   [NVEC] = '{4, 6, 2, 3, 9, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] len = '0;
   logic [6:0]  base = '0;
   logic        busy, err;
   logic [11:0] rd_idx;
   logic [31:0] rd_word;
   logic [6:0]  poll_win;
   logic [31:0] poll_stat = '0;
   logic        wr_valid, wr_ready;
   logic [6:0]  wr_win;
   logic [31:0] wr_data;

   logic        stall_en = 1'b0;
   int          cyc_q = 0;
   logic [31:0] msg [64];

   int          total = 0;
   int          bad = 0;
   int          nlog = 0;
   logic [6:0]  got_win  [64];
   logic [31:0] got_data [64];
   int          exp_n = 0;
   logic [6:0]  exp_win  [64];
   logic [31:0] exp_data [64];
   int          stab_bad = 0;
   int          r7_bad = 0;
   logic        prev_hs = 1'b0;
   logic        prev_stall = 1'b0;
   logic [6:0]  pw;
   logic [31:0] pd;
   logic        r7_watch = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign wr_ready = !stall_en || cyc_q[0];
   assign rd_word  = msg[rd_idx[5:0]];

   mbx_msg_tx i_mbx_msg_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .len_i       (len),
      .base_i      (base),
      .busy_o      (busy),
      .err_o       (err),
      .rd_idx_o    (rd_idx),
      .rd_word_i   (rd_word),
      .poll_win_o  (poll_win),
      .poll_stat_i (poll_stat),
      .wr_valid_o  (wr_valid),
      .wr_ready_i  (wr_ready),
      .wr_win_o    (wr_win),
      .wr_data_o   (wr_data)
   );

   task automatic report;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc_q <= cyc_q + 1;
      if (cyc_q == 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog R7: run did not finish, actual=%0d expected<150000", cyc_q);
         report();
      end
   end

   // observer: writes, hold stability (R9), end timing (R7)
   always @(negedge clk) begin
      if (prev_stall && !(wr_valid && wr_win == pw && wr_data == pd))
         stab_bad++;
      if (r7_watch && prev_hs && nlog == exp_n && busy)
         r7_bad++;
      prev_stall = wr_valid && !wr_ready;
      pw = wr_win;
      pd = wr_data;
      prev_hs = wr_valid && wr_ready;
      if (wr_valid && wr_ready) begin
         if (nlog < 64) begin
            got_win[nlog]  = wr_win;
            got_data[nlog] = wr_data;
         end
         nlog++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic fill_msg;
      for (int j = 0; j < 64; j++)
         msg[j] = {8'(j + 1), 8'hA5, 8'(3 * j + 1), 8'(8'h10 + j)};
   endtask

   // expected write list, derived from R2, R5, R6, R7
   task automatic build_exp(input int blen, input int bbase);
      int left, idx, rb, k;
      logic [31:0] w;
      left = blen; idx = 0; exp_n = 0;
      while (left > 0) begin
         rb = (left < 4 * WPC) ? left : 4 * WPC;
         for (int i = WPC - 1; i >= 0; i--) begin
            if (rb <= 4 * i) continue;
            k = rb % 4;
            w = msg[idx + i];
            if (k != 0) w = w & ((32'h1 << (8 * k)) - 32'h1);
            else k = 4;
            exp_win[exp_n]  = 7'(bbase + WPC - 1 - i);
            exp_data[exp_n] = w;
            exp_n++;
            left -= k;
            rb   -= k;
         end
         idx += WPC;
      end
   endtask

   task automatic pulse_start(input int plen, input int pbase);
      @(negedge clk);
      len   = 12'(plen);
      base  = 7'(pbase);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle;
      int n;
      n = 0;
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 3000) chk(1'b0, "R7 watchdog", 64'(n), 64'd0);
   endtask

   task automatic cmp_writes(input int upto, input string req);
      for (int e = 0; e < upto; e++)
         chk({got_win[e], got_data[e]} == {exp_win[e], exp_data[e]}, req,
             {25'd0, got_win[e], got_data[e]}, {25'd0, exp_win[e], exp_data[e]});
   endtask

   initial begin
      fill_msg();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !err && !wr_valid, "R1 during reset", {61'd0, busy, err, wr_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !err && !wr_valid, "R1 after reset", {61'd0, busy, err, wr_valid}, 64'd0);

      // table walk: R2 R3 R5 R6 R7 R9
      for (int v = 0; v < NVEC; v++) begin
         fill_msg();
         stall_en = VSTALL[v][0];
         build_exp(VLEN[v], VBASE[v]);
         nlog = 0;
         r7_watch = 1'b1;
         pulse_start(VLEN[v], VBASE[v]);
         chk(poll_win == 7'(VBASE[v] + WPC - 1), "R3 poll window", 64'(poll_win), 64'(VBASE[v] + WPC - 1));
         wait_idle();
         r7_watch = 1'b0;
         chk(nlog == VNW[v] && exp_n == VNW[v], "R5 write count", 64'(nlog), 64'(VNW[v]));
         cmp_writes(VNW[v], "R2 R6 window/data");
         chk(!err, "R7 clean end", 64'(err), 64'd0);
      end
      stall_en = 1'b0;

      // R4: zero leading word in the second round
      fill_msg();
      msg[4] = '0;
      build_exp(24, 0);
      nlog = 0;
      pulse_start(24, 0);
      wait_idle();
      chk(err && !busy, "R4 error on zero word", {62'd0, err, busy}, 64'h2);
      chk(nlog == 4, "R4 writes before abort", 64'(nlog), 64'd4);
      cmp_writes(4, "R4 first round data");
      repeat (5) @(negedge clk);
      chk(err, "R10 error sticky", 64'(err), 64'd1);

      // R10: zero-length start clears error, no writes, stays idle
      nlog = 0;
      pulse_start(0, 0);
      chk(!err && !busy, "R10 zero length clears", {62'd0, err, busy}, 64'd0);
      repeat (3) @(negedge clk);
      chk(nlog == 0, "R10 zero length writes", 64'(nlog), 64'd0);

      // R4: zero word at the very first round
      fill_msg();
      msg[0] = '0;
      nlog = 0;
      pulse_start(8, 30);
      wait_idle();
      chk(err && nlog == 0, "R4 abort first round", {31'd0, err, 32'(nlog)}, {31'd0, 1'b1, 32'd0});

      // R3: nonzero status holds the round back
      fill_msg();
      build_exp(8, 20);
      poll_stat = 32'h1;
      nlog = 0;
      pulse_start(8, 20);
      repeat (12) @(negedge clk);
      chk(busy && nlog == 0 && !err, "R3 held by status", {31'd0, busy, 32'(nlog)}, {31'd0, 1'b1, 32'd0});
      poll_stat = '0;
      wait_idle();
      chk(nlog == 2, "R3 released count", 64'(nlog), 64'd2);
      cmp_writes(2, "R3 released data");

      // R8: start while busy is ignored
      fill_msg();
      build_exp(16, 0);
      stall_en = 1'b1;
      nlog = 0;
      pulse_start(16, 0);
      pulse_start(4, 60);
      wait_idle();
      stall_en = 1'b0;
      chk(nlog == 4, "R8 refused start count", 64'(nlog), 64'd4);
      cmp_writes(4, "R8 original message kept");
      repeat (3) @(negedge clk);
      chk(!busy && nlog == 4, "R8 no late transfer", {31'd0, busy, 32'(nlog)}, {31'd0, 1'b0, 32'd4});

      chk(stab_bad == 0, "R9 hold while stalled", 64'(stab_bad), 64'd0);
      chk(r7_bad == 0, "R7 busy falls after last write", 64'(r7_bad), 64'd0);
      report();
   end

endmodule